// File: doc/BRIEF.md
# Dual-Output Serial Flash Read Responder

This block is the device-side answer logic for a dual-output read on a serial flash. When chip select falls, it collects a serial header on IO0, one bit per rising edge of the serial clock. The header is an 8-bit opcode, a 24-bit start address and 8 dummy bits. It then streams array bytes back on IO0 and IO1 together, two bits per serial clock, and steps the address after every byte.

The serial clock and chip select are sampled by the block's system clock. Every serial clock phase must therefore last at least two system clock cycles. The array sits behind a synchronous read port: data arrives one system clock after the read strobe. The block fetches each byte ahead of time, so bytes follow one another with no gap. A busy flag from the program/erase engine makes the block ignore the command. A wrong opcode is also ignored.

Top module: `spi_dor_resp`

## Requirements
- R1: After reset, both output enables are low and no array read is requested.
- R2: Bits are captured on IO0 at each serial clock rising edge, most significant bit first, in this order: the opcode 8'h3B, then 24 address bits, then 8 dummy bits. On the 40th rising edge the block issues an array read of the low MEM_AW address bits.
- R3: Both output enables stay low through the whole header. They rise only after a serial clock falling edge, namely the one that follows the 40th rising edge. After that, the output bits change only after falling edges and hold steady while the serial clock is high.
- R4: In each output clock, IO1 carries the higher bit and IO0 the lower bit. A byte leaves as the pairs 7/6, 5/4, 3/2, 1/0.
- R5: After each byte, the next higher array location follows with no gap. It is fetched while the last pair of the current byte is on the lines, so n complete bytes cost n+1 reads.
- R6: After location 2^MEM_AW-1, the stream continues at location 0.
- R7: While chip select is high, no read is requested, and both output enables are low one system clock after it rises. This holds in the middle of a byte as well. The next transaction starts from a clean header.
- R8: An opcode other than 8'h3B leaves both output enables low and requests no read until chip select rises.
- R9: If busy_i is high when the last opcode bit is captured, the command is ignored: both output enables stay low and no read is requested.
- R10: The two output enables are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock |
| io0_i | input | 1 | IO0 input (header bits) |
| busy_i | input | 1 | Program/erase/register-write operation running |
| io0_o | output | 1 | IO0 output data (lower bit of pair) |
| io0_oe_o | output | 1 | IO0 output enable |
| io1_o | output | 1 | IO1 output data (higher bit of pair) |
| io1_oe_o | output | 1 | IO1 output enable |
| mem_rd_o | output | 1 | Array read strobe |
| mem_addr_o | output | MEM_AW | Array read address |
| mem_data_i | input | 8 | Array read data, valid one clock after the strobe |

## Verification
The assertions take for granted that the serial clock and chip select are slow compared with the system clock. Each serial clock level must last at least two system clocks, and chip select must stay low for at least one system clock before the first rising edge. Without that, edge detection and the "changes only after a falling edge" property have no meaning. The stimulus drives every serial clock phase for four system clocks, changes IO0 only while the serial clock is low, and waits two clocks after chip select falls. Chip select is raised only while the serial clock is low.

// File: rtl/spi_dor_pkg.sv
package spi_dor_pkg;
  localparam int OP_W     = 8;
  localparam int ADDR_W   = 24;
  localparam int DUMMY_W  = 8;
  localparam int HDR_BITS = OP_W + ADDR_W + DUMMY_W;
  localparam int CNT_W    = $clog2(HDR_BITS);
  localparam logic [OP_W-1:0] OPC_DOR = 8'h3B;

  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_DATA = 2'd1,
    ST_IGN  = 2'd2
  } state_e;
endpackage

// File: rtl/spi_dor_edge.sv
module spi_dor_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic rise_o,
  output logic fall_o
);
  logic sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_i;
  end

  assign rise_o = sclk_i & ~sclk_q;
  assign fall_o = ~sclk_i & sclk_q;
endmodule

// File: rtl/spi_dor_ctrl.sv
module spi_dor_ctrl
  import spi_dor_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              io0_i,
  input  logic              busy_i,
  output logic              load_o,
  output logic              shift_o,
  output logic              mem_rd_o,
  output logic [MEM_AW-1:0] mem_addr_o
);
  localparam logic [CNT_W-1:0] OP_LAST   = CNT_W'(OP_W - 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(OP_W + ADDR_W - 1);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_BITS - 1);

  state_e            state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] sreg_q;
  logic [MEM_AW-1:0] addr_q;
  logic [1:0]        pair_q;
  logic [OP_W-1:0]   opc_w;
  logic              rd_first, rd_next, in_data;

  assign opc_w    = {sreg_q[OP_W-2:0], io0_i};
  assign in_data  = !cs_ni && state_q == ST_DATA;
  assign rd_first = !cs_ni && state_q == ST_HDR && rise_i && cnt_q == HDR_LAST;
  assign rd_next  = in_data && fall_i && pair_q == 2'd3;
  assign load_o   = in_data && fall_i && pair_q == 2'd0;
  assign shift_o  = in_data && fall_i && pair_q != 2'd0;
  assign mem_rd_o = rd_first | rd_next;
  // in data phase the prefetch targets the following location
  assign mem_addr_o = (state_q == ST_DATA) ? addr_q + 1'b1 : addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HDR;
      cnt_q   <= '0;
      sreg_q  <= '0;
      addr_q  <= '0;
      pair_q  <= '0;
    end else if (cs_ni) begin
      state_q <= ST_HDR;
      cnt_q   <= '0;
      pair_q  <= '0;
    end else begin
      unique case (state_q)
        ST_HDR: if (rise_i) begin
          sreg_q <= {sreg_q[ADDR_W-2:0], io0_i};
          cnt_q  <= cnt_q + 1'b1;
          if (cnt_q == OP_LAST && (opc_w != OPC_DOR || busy_i)) state_q <= ST_IGN;
          if (cnt_q == ADDR_LAST) addr_q <= {sreg_q[MEM_AW-2:0], io0_i};
          if (cnt_q == HDR_LAST) begin
            state_q <= ST_DATA;
            pair_q  <= '0;
          end
        end
        ST_DATA: if (fall_i) begin
          pair_q <= pair_q + 1'b1;
          if (pair_q == 2'd3) addr_q <= addr_q + 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/spi_dor_shift.sv
module spi_dor_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       load_i,
  input  logic       shift_i,
  input  logic       rd_i,
  input  logic [7:0] mem_data_i,
  output logic       hi_o,
  output logic       lo_o,
  output logic       oe_o
);
  logic [7:0] buf_q, sh_q;
  logic       rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      sh_q  <= '0;
      rd_q  <= 1'b0;
      oe_o  <= 1'b0;
    end else begin
      rd_q <= rd_i;
      if (rd_q) buf_q <= mem_data_i;
      if (load_i)       sh_q <= buf_q;
      else if (shift_i) sh_q <= {sh_q[5:0], 2'b00};
      if (cs_ni)       oe_o <= 1'b0;
      else if (load_i) oe_o <= 1'b1;
    end
  end

  assign hi_o = sh_q[7];
  assign lo_o = sh_q[6];
endmodule

// File: rtl/spi_dor_resp.sv
module spi_dor_resp
  import spi_dor_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              io0_i,
  input  logic              busy_i,
  output logic              io0_o,
  output logic              io0_oe_o,
  output logic              io1_o,
  output logic              io1_oe_o,
  output logic              mem_rd_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  input  logic [7:0]        mem_data_i
);
  logic rise, fall, load, shift, oe;

  spi_dor_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .rise_o(rise), .fall_o(fall)
  );

  spi_dor_ctrl #(.MEM_AW(MEM_AW)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .rise_i(rise), .fall_i(fall),
    .io0_i(io0_i), .busy_i(busy_i), .load_o(load), .shift_o(shift),
    .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o)
  );

  spi_dor_shift u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .load_i(load), .shift_i(shift),
    .rd_i(mem_rd_o), .mem_data_i(mem_data_i), .hi_o(io1_o), .lo_o(io0_o), .oe_o(oe)
  );

  assign io0_oe_o = oe;
  assign io1_oe_o = oe;
endmodule

// File: rtl/spi_dor_resp_sva.sv
module spi_dor_resp_sva #(
  parameter int MEM_AW = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              sclk_i,
  input logic              io0_o,
  input logic              io0_oe_o,
  input logic              io1_o,
  input logic              io1_oe_o,
  input logic              mem_rd_o,
  input logic [MEM_AW-1:0] mem_addr_o
);
  a_r7_release_on_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (!io0_oe_o && !io1_oe_o));

  a_r7_no_read_cs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !mem_rd_o);

  a_r10_oe_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io0_oe_o == io1_oe_o);

  a_r3_oe_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(io0_oe_o) |-> !$past(sclk_i));

  a_r3_data_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io0_oe_o && $past(io0_oe_o) && ({io1_o, io0_o} != $past({io1_o, io0_o})))
      |-> !$past(sclk_i));

  a_r1_addr_known: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> !$isunknown(mem_addr_o));
endmodule

bind spi_dor_resp spi_dor_resp_sva #(.MEM_AW(MEM_AW)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk_i),
  .io0_o(io0_o), .io0_oe_o(io0_oe_o), .io1_o(io1_o), .io1_oe_o(io1_oe_o),
  .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o)
);

// File: tb/spi_dor_resp_tb_top.sv
module spi_dor_resp_tb_top;
  localparam int MEM_AW = 8;
  localparam int NV = 4;
  localparam logic [23:0] V_ADDR [NV] = '{24'h000010, 24'hABCD05, 24'h0000FE, 24'h000000};
  localparam int          V_LEN  [NV] = '{3, 2, 4, 1};

  logic clk_i = 1'b0, rst_ni = 1'b0, cs_ni = 1'b1, sclk_i = 1'b0, io0_i = 1'b0, busy_i = 1'b0;
  logic io0_o, io0_oe_o, io1_o, io1_oe_o, mem_rd_o;
  logic [MEM_AW-1:0] mem_addr_o;
  logic [7:0] mem_data_i = '0;
  int checks = 0, errors = 0, rd_cnt = 0, oe_cnt = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  spi_dor_resp #(.MEM_AW(MEM_AW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk_i), .io0_i(io0_i),
    .busy_i(busy_i), .io0_o(io0_o), .io0_oe_o(io0_oe_o), .io1_o(io1_o),
    .io1_oe_o(io1_oe_o), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
    .mem_data_i(mem_data_i)
  );

  function automatic logic [7:0] mem_f(logic [MEM_AW-1:0] a);
    return 8'(a) * 8'd29 + 8'h5B;
  endfunction

  always @(posedge clk_i) begin
    if (mem_rd_o) begin
      mem_data_i <= mem_f(mem_addr_o);
      rd_cnt <= rd_cnt + 1;
    end
    if (io0_oe_o || io1_oe_o) oe_cnt <= oe_cnt + 1;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wn(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic send_hdr(logic [7:0] opc, logic [23:0] addr, output int oe_seen);
    logic [39:0] bits;
    int oe0;
    bits = {opc, addr, 8'h00};
    oe0 = oe_cnt;
    cs_ni = 1'b0;
    wn(2);
    for (int i = 0; i < 40; i++) begin
      io0_i = bits[39-i];
      wn(4);
      sclk_i = 1'b1;
      wn(4);
      if (i == 39) oe_seen = oe_cnt - oe0;
      sclk_i = 1'b0;
    end
  endtask

  task automatic read_byte(output logic [7:0] b, output bit stable, output bit oe_ok);
    logic [1:0] p;
    stable = 1; oe_ok = 1;
    for (int k = 0; k < 4; k++) begin
      wn(4);
      p = {io1_o, io0_o};
      if (!(io0_oe_o && io1_oe_o)) oe_ok = 0;
      sclk_i = 1'b1;
      wn(4);
      if ({io1_o, io0_o} != p) stable = 0;
      sclk_i = 1'b0;
      b = {b[5:0], p};
    end
  endtask

  task automatic end_cs();
    wn(2);
    cs_ni = 1'b1;
    wn(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    bit st, ok;
    int oe_seen, rd0, oe0;
    wn(3);
    // R1 reset state
    chk(!io0_oe_o && !io1_oe_o, "R1 oe after reset", {io1_oe_o, io0_oe_o}, 0);
    chk(!mem_rd_o, "R1 no read after reset", mem_rd_o, 0);
    rst_ni = 1'b1;
    wn(2);

    // vector table: R2 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      rd0 = rd_cnt;
      send_hdr(8'h3B, V_ADDR[v], oe_seen);
      chk(oe_seen == 0, "R3 oe low in header", oe_seen, 0);
      for (int n = 0; n < V_LEN[v]; n++) begin
        read_byte(b, st, ok);
        chk(b == mem_f(MEM_AW'(V_ADDR[v][MEM_AW-1:0] + n)), "R2/R4/R5/R6 data byte",
            b, mem_f(MEM_AW'(V_ADDR[v][MEM_AW-1:0] + n)));
        chk(st, "R3 stable while sclk high", st, 1);
        chk(ok, "R10 both oe high in data", ok, 1);
      end
      chk(rd_cnt - rd0 == V_LEN[v] + 1, "R5 read count", rd_cnt - rd0, V_LEN[v] + 1);
      end_cs();
      chk(!io0_oe_o && !io1_oe_o, "R7 released after cs", {io1_oe_o, io0_oe_o}, 0);
    end

    // R7 cs raised mid-byte, then a clean transaction
    send_hdr(8'h3B, 24'h000020, oe_seen);
    wn(4); sclk_i = 1'b1; wn(4); sclk_i = 1'b0;
    wn(4); sclk_i = 1'b1; wn(4); sclk_i = 1'b0;
    wn(1);
    chk(io0_oe_o, "R7 driving mid-byte", io0_oe_o, 1);
    cs_ni = 1'b1;
    wn(2);
    chk(!io0_oe_o && !io1_oe_o, "R7 mid-byte release", {io1_oe_o, io0_oe_o}, 0);
    send_hdr(8'h3B, 24'h000031, oe_seen);
    read_byte(b, st, ok);
    chk(b == mem_f(8'h31), "R7 fresh transaction after abort", b, mem_f(8'h31));
    end_cs();

    // R8 wrong opcode
    rd0 = rd_cnt; oe0 = oe_cnt;
    send_hdr(8'h0B, 24'h000040, oe_seen);
    read_byte(b, st, ok);
    read_byte(b, st, ok);
    chk(rd_cnt == rd0, "R8 no read on wrong opcode", rd_cnt - rd0, 0);
    chk(oe_cnt == oe0, "R8 no drive on wrong opcode", oe_cnt - oe0, 0);
    end_cs();

    // R9 busy during opcode
    busy_i = 1'b1;
    rd0 = rd_cnt; oe0 = oe_cnt;
    send_hdr(8'h3B, 24'h000050, oe_seen);
    busy_i = 1'b0;
    read_byte(b, st, ok);
    read_byte(b, st, ok);
    chk(rd_cnt == rd0, "R9 no read while busy", rd_cnt - rd0, 0);
    chk(oe_cnt == oe0, "R9 no drive while busy", oe_cnt - oe0, 0);
    end_cs();

    // R9 after busy clears, command works again
    send_hdr(8'h3B, 24'h0000FF, oe_seen);
    read_byte(b, st, ok);
    chk(b == mem_f(8'hFF), "R9 accepted when idle", b, mem_f(8'hFF));
    read_byte(b, st, ok);
    chk(b == mem_f(8'h00), "R6 wrap to zero", b, mem_f(8'h00));
    end_cs();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule